// File: doc/BRIEF.md
# Reconfiguration Register Port

This block holds the live settings of a clocking function and gives a host on the fabric a small synchronous register port to change them. The port looks like a block RAM. It has one address bus, one write-data bus and one read-data bus, an enable, a write-enable and a ready strobe. Each stored field drives an output that goes straight to the controlled logic: a multiply setting, a divide setting, a phase-shift setting and a few function-enable bits. A status word supplied from outside can be read back.

The multiply and divide settings are stored as the wanted value minus one. Their outputs present the effective value. A write finishes with a ready pulse in the cycle after the enable cycle. A read finishes two cycles after the enable cycle, and its data is valid only while ready is high. One address is shared by two functions: writing it sets the write-only enables, and reading it returns the read-only status. While a read is in flight, the host must wait for ready before it issues another transaction.

Top module: `cfg_regport`

## Requirements
- R1: After reset the port reports these values: multiply output 4 (stored code 3), divide output 1 (code 0), phase 0, function enables 0, and ready low.
- R2: When enable and write-enable are high in a cycle and the port is idle, the addressed field takes the write data at the next rising edge. Ready is then high for the cycle that follows.
- R3: A read presented while the port is idle drives ready low in the first cycle after the enable cycle. In the second cycle it drives ready high, with read data equal to the addressed content, zero-extended.
- R4: Address 0x50 holds the multiply code in bits 7:0, and the multiply output equals code + 1, so writing 0x0004 gives 5. Address 0x51 holds the divide code in bits 7:0, with divide output equal to code + 1.
- R5: Address 0x41 is shared. A write loads bits 3:0 into the function-enable output, and a read returns the 16-bit status input instead of the enables.
- R6: Addresses other than 0x41, 0x50, 0x51 and 0x55 read as zero. A write to them changes no output, but it still completes with a ready pulse.
- R7: Whenever ready is low, the read-data bus is zero. A write completion also shows zero on the read-data bus.
- R8: An enable asserted while a read is in flight is ignored. It produces no extra ready pulse and changes no field.
- R9: Fields narrower than the data bus keep only the low write-data bits. Address 0x55 holds a 10-bit phase value in bits 9:0, and the upper bits read back as zero.
- R10: Each completed transaction raises ready for exactly one cycle. Ready is never high unless a transaction precedes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transaction enable |
| we | input | 1 | Write select, qualified by en |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rdy is high |
| rdy | output | 1 | One-cycle completion strobe |
| status_in | input | 16 | Read-only status word |
| mult_val | output | 9 | Effective multiply value |
| div_val | output | 9 | Effective divide value |
| phase_val | output | 10 | Phase-shift setting |
| func_en | output | 4 | Write-only function enables |

## Verification
The register map is driven with several kinds of traffic, and each kind separates a different class of fault.

- A read of the reset defaults separates a wrong reset value from a wrong decode.
- Writes of small codes followed by readbacks show whether the minus-one encoding is applied on the output side only.
- All-ones and mixed patterns sent to the narrow fields expose wrong truncation and wrong zero-extension.
- Traffic to the shared address, with a status word unlike the written enables, shows whether the read and write paths are swapped.
- Unmapped writes, back-to-back writes, and an enable raised in the middle of a read each check something different:
  - whether writes are filtered by address;
  - whether ready is one cycle wide;
  - whether the busy interlock holds.

// File: rtl/cfg_regport.sv
module cfg_regport #(
  parameter int AW        = 7,
  parameter int DW        = 16,
  parameter int MULT_W    = 8,
  parameter int DIV_W     = 8,
  parameter int PHASE_W   = 10,
  parameter int EN_W      = 4,
  parameter int MULT_ADDR = 'h50,
  parameter int DIV_ADDR  = 'h51,
  parameter int PH_ADDR   = 'h55,
  parameter int SHR_ADDR  = 'h41,
  parameter int MULT_DEF  = 3,
  parameter int DIV_DEF   = 0,
  parameter int PH_DEF    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdy,
  input  logic [DW-1:0]     status_in,
  output logic [MULT_W:0]   mult_val,
  output logic [DIV_W:0]    div_val,
  output logic [PHASE_W-1:0] phase_val,
  output logic [EN_W-1:0]   func_en
);

  localparam logic [AW-1:0] A_MULT = AW'(MULT_ADDR);
  localparam logic [AW-1:0] A_DIV  = AW'(DIV_ADDR);
  localparam logic [AW-1:0] A_PH   = AW'(PH_ADDR);
  localparam logic [AW-1:0] A_SHR  = AW'(SHR_ADDR);

  logic [MULT_W-1:0]  mult_q;
  logic [DIV_W-1:0]   div_q;
  logic [PHASE_W-1:0] ph_q;
  logic [EN_W-1:0]    fen_q;
  logic               busy;
  logic               rdy_q;
  logic [AW-1:0]      raddr_q;
  logic [DW-1:0]      rdata_q;
  logic [DW-1:0]      rd_mux;

  wire take = en && !busy;
  wire wr   = take && we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= MULT_W'(MULT_DEF);
      div_q  <= DIV_W'(DIV_DEF);
      ph_q   <= PHASE_W'(PH_DEF);
      fen_q  <= '0;
    end else if (wr) begin
      case (addr)
        A_MULT:  mult_q <= MULT_W'(wdata);
        A_DIV:   div_q  <= DIV_W'(wdata);
        A_PH:    ph_q   <= PHASE_W'(wdata);
        A_SHR:   fen_q  <= EN_W'(wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr_q)
      A_MULT:  rd_mux = DW'(mult_q);
      A_DIV:   rd_mux = DW'(div_q);
      A_PH:    rd_mux = DW'(ph_q);
      A_SHR:   rd_mux = status_in;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rdy_q   <= 1'b0;
      raddr_q <= '0;
      rdata_q <= '0;
    end else begin
      busy    <= take && !we;
      rdy_q   <= wr || busy;
      rdata_q <= busy ? rd_mux : '0;
      if (take) raddr_q <= addr;
    end
  end

  assign rdy       = rdy_q;
  assign rdata     = rdy_q ? rdata_q : '0;
  assign mult_val  = {1'b0, mult_q} + 1'b1;
  assign div_val   = {1'b0, div_q} + 1'b1;
  assign phase_val = ph_q;
  assign func_en   = fen_q;

endmodule

module cfg_regport_chk #(
  parameter int AW = 7, parameter int DW = 16, parameter int MULT_W = 8,
  parameter int DIV_W = 8, parameter int PHASE_W = 10, parameter int EN_W = 4
) (
  input logic clk, rst, en, we, busy, rdy,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic [MULT_W:0] mult_val,
  input logic [DIV_W:0] div_val,
  input logic [PHASE_W-1:0] phase_val,
  input logic [EN_W-1:0] func_en
);
  wire mapped = (addr == AW'('h50)) || (addr == AW'('h51)) ||
                (addr == AW'('h55)) || (addr == AW'('h41));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> rdata == '0);
  // R2
  wr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (en && we && !busy) |=> rdy);
  // R3
  rd_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !we && !busy) |=> (!rdy ##1 rdy));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && en && we) |=> ($stable(mult_val) && $stable(div_val) &&
                            $stable(phase_val) && $stable(func_en)));
  // R6
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (en && we && !busy && !mapped) |=> ($stable(mult_val) && $stable(div_val) &&
                                        $stable(phase_val) && $stable(func_en)));
  // R10
  rdy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> ($past(en && we) || $past(busy)));
endmodule

bind cfg_regport cfg_regport_chk #(
  .AW(AW), .DW(DW), .MULT_W(MULT_W), .DIV_W(DIV_W), .PHASE_W(PHASE_W), .EN_W(EN_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .we(we), .busy(busy), .rdy(rdy),
  .addr(addr), .rdata(rdata), .mult_val(mult_val), .div_val(div_val),
  .phase_val(phase_val), .func_en(func_en)
);

// File: tb/sim_cfg_regport.sv
`timescale 1ns/1ps
module sim_cfg_regport;
  logic clk = 0, rst = 1, en = 0, we = 0;
  logic [6:0] addr = '0;
  logic [15:0] wdata = '0, status_in = '0, rdata;
  logic rdy;
  logic [8:0] mult_val, div_val;
  logic [9:0] phase_val;
  logic [3:0] func_en;
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cfg_regport u0 (.clk(clk), .rst(rst), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdy(rdy), .status_in(status_in),
    .mult_val(mult_val), .div_val(div_val), .phase_val(phase_val),
    .func_en(func_en));

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: pops expected completions and checks idle read bus
  initial forever begin
    @(negedge clk); #1;
    if (!rst) begin
      if (rdy) begin
        if (exp_q.size() == 0) chk("R10 unexpected rdy", 16'd1, 16'd0);
        else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end else if (rdata !== 16'd0) chk("R7 idle rdata", rdata, 16'd0);
    end
  end

  // drives one transaction and waits until its ready cycle
  task automatic txn(input logic w, input logic [6:0] a, input logic [15:0] d,
                     input logic [15:0] exp, input string r);
    @(negedge clk);
    en = 1; we = w; addr = a; wdata = d;
    exp_q.push_back(exp); tag_q.push_back(r);
    @(negedge clk);
    en = 0; we = 0;
    if (!w) begin
      #1 chk({r, " rdy low first cycle"}, {15'd0, rdy}, 16'd0);
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string r);
    @(negedge clk); #1;
    chk({r, " rdy one cycle"}, {15'd0, rdy}, 16'd0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 mult", 16'(mult_val), 16'd4);
    chk("R1 div", 16'(div_val), 16'd1);
    chk("R1 phase", 16'(phase_val), 16'd0);
    chk("R1 func_en", 16'(func_en), 16'd0);
    chk("R1 rdy", {15'd0, rdy}, 16'd0);
    txn(0, 7'h50, 16'h0, 16'h0003, "R3 read default mult");
    quiet("R10");
    txn(1, 7'h50, 16'h0004, 16'h0000, "R2 R7 write ack");
    #1 chk("R4 mult 5", 16'(mult_val), 16'd5);
    quiet("R10");
    txn(1, 7'h51, 16'h0002, 16'h0000, "R2 div write");
    #1 chk("R4 div 3", 16'(div_val), 16'd3);
    txn(0, 7'h51, 16'h0, 16'h0002, "R3 div readback");
    txn(1, 7'h55, 16'hFFFF, 16'h0000, "R9 phase write");
    #1 chk("R9 phase trunc", 16'(phase_val), 16'h03FF);
    txn(0, 7'h55, 16'h0, 16'h03FF, "R9 phase readback");
    txn(1, 7'h50, 16'hABCD, 16'h0000, "R9 mult write");
    #1 chk("R9 R4 mult trunc", 16'(mult_val), 16'h00CE);
    txn(0, 7'h50, 16'h0, 16'h00CD, "R9 mult readback");
    status_in = 16'hA5C3;
    txn(1, 7'h41, 16'hFFF9, 16'h0000, "R5 shared write");
    #1 chk("R5 func_en", 16'(func_en), 16'h0009);
    txn(0, 7'h41, 16'h0, 16'hA5C3, "R5 shared read status");
    txn(1, 7'h7F, 16'h1234, 16'h0000, "R6 unmapped write ack");
    txn(1, 7'h00, 16'hFFFF, 16'h0000, "R6 unmapped write ack");
    #1;
    chk("R6 mult kept", 16'(mult_val), 16'h00CE);
    chk("R6 div kept", 16'(div_val), 16'd3);
    chk("R6 phase kept", 16'(phase_val), 16'h03FF);
    chk("R6 func_en kept", 16'(func_en), 16'h0009);
    txn(0, 7'h7F, 16'h0, 16'h0000, "R6 unmapped read");
    txn(0, 7'h52, 16'h0, 16'h0000, "R6 unmapped read");
    // R8: enable during read in flight
    @(negedge clk);
    en = 1; we = 0; addr = 7'h51;
    exp_q.push_back(16'h0002); tag_q.push_back("R8 read under collision");
    @(negedge clk);
    en = 1; we = 1; addr = 7'h51; wdata = 16'h0077;
    @(negedge clk);
    en = 0; we = 0;
    quiet("R8 no extra rdy");
    #1 chk("R8 div unchanged", 16'(div_val), 16'd3);
    txn(0, 7'h51, 16'h0, 16'h0002, "R8 div readback");
    // R10: back-to-back writes give one pulse each
    txn(1, 7'h51, 16'h0000, 16'h0000, "R10 b2b write1");
    txn(1, 7'h50, 16'h0000, 16'h0000, "R10 b2b write2");
    #1 chk("R4 mult 1", 16'(mult_val), 16'd1);
    chk("R4 div 1", 16'(div_val), 16'd1);
    quiet("R10");
    repeat (2) @(negedge clk);
    chk("R10 queue drained", 16'(exp_q.size()), 16'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule